// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit logical address into a physical address. It does this by reading a two-level translation table that is held in memory. Pages are 8 KB. The low 13 bits of the address pass through unchanged. The 19-bit page number splits into a 10-bit directory index and a 9-bit leaf index. A directory entry gives the physical location of a leaf table, and the leaf entry gives the physical frame. A table base register and a table length register set where the directory sits and how far it reaches. Both registers can be written only while a privileged-mode input is high.

A client presents a request with valid/ready. The walker then issues at most two word reads through a simple memory port. The port uses a valid/ready request phase and a one-cycle response strobe. For each request the walker returns exactly one single-cycle result: either a physical address, or a fault with a two-bit cause. An out-of-range directory index faults before any memory traffic. An absent directory entry faults after one read.

Table entry format (both levels, 32 bits): bit 0 present, bit 1 referenced, bit 2 modified, bit 3 write permitted, bit 4 user access permitted, bits 31:13 frame number. For a directory entry, the frame number is the 8 KB-aligned physical base of the leaf table.

Top module: `pt_walker`

## Requirements
- R1: On success, rspPhysAddr equals the leaf entry bits 31:13 followed by the request address bits 12:0, with rspCause 0. On any fault, rspPhysAddr is 0.
- R2: The first read address is tableBase + 4 × reqAddr[31:22].
- R3: The second read address is {directory entry bits 31:13, 13'b0} + 4 × reqAddr[21:13].
- R4: If reqAddr[31:22] is greater than the length register, the walker faults with cause 0 and makes no memory read. The result appears in the cycle after the request is accepted. An index equal to the length register is legal.
- R5: A directory entry with bit 0 clear faults with cause 1 and makes no second read.
- R6: A leaf entry with bit 0 clear faults with cause 2.
- R7: A present leaf entry faults with cause 3 in either of two cases: the request is a write and bit 3 is clear, or the request is a user access and bit 4 is clear. An absent leaf entry reports cause 2 even when its permission bits would also fail.
- R8: A config write with cfgSel 0 loads tableBase from cfgData. With cfgSel 1 it loads the length register from cfgData[9:0]. A config write while sysMode is low changes neither register.
- R9: reqReady is high only when no walk is in progress. memReqValid stays high with a stable address until memReqReady is seen. rspValid is a single-cycle pulse, after which reqReady is high again.
- R10: During and right after reset: reqReady is 1, memReqValid is 0, rspValid is 0, and both config registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sysMode | input | 1 | Privileged mode; gates config writes |
| cfgWrEn | input | 1 | Config register write strobe |
| cfgSel | input | 1 | 0 selects table base, 1 selects length |
| cfgData | input | 32 | Config write data |
| reqValid | input | 1 | Translation request valid |
| reqReady | output | 1 | Walker idle, request accepted |
| reqAddr | input | 32 | Logical address to translate |
| reqWrite | input | 1 | Access is a write |
| reqUser | input | 1 | Access is from user mode |
| memReqValid | output | 1 | Table read request valid |
| memReqReady | input | 1 | Memory accepts the read |
| memReqAddr | output | 32 | Physical address of the table word |
| memRspValid | input | 1 | Read data strobe |
| memRspData | input | 32 | Table entry returned |
| rspValid | output | 1 | Result pulse |
| rspFault | output | 1 | Translation faulted |
| rspCause | output | 2 | 0 length, 1 directory absent, 2 leaf absent, 3 permission |
| rspPhysAddr | output | 32 | Translated physical address |

## Verification
Four properties are checked on every cycle:
- a stalled memory request holds its address;
- the result is a lone pulse that returns the walker to idle;
- an out-of-range index yields a cause-0 fault one cycle after acceptance;
- every successful translation keeps the request's page offset, and a config write in user mode leaves both registers untouched.

Other behaviours depend on table contents that only the bench controls, so only its scenarios can show them. These are the exact read addresses at each level, the number of reads per walk, the choice among the four fault causes, and the ordering of absence before permission.

// File: rtl/pt_walk_pkg.sv
package pt_walk_pkg;

  localparam int PRESENT_BIT = 0;
  localparam int REFD_BIT    = 1;
  localparam int MOD_BIT     = 2;
  localparam int WRITE_BIT   = 3;
  localparam int USER_BIT    = 4;

  typedef enum logic [1:0] {
    CAUSE_LEN  = 2'd0,
    CAUSE_DIR  = 2'd1,
    CAUSE_LEAF = 2'd2,
    CAUSE_PERM = 2'd3
  } faultCause_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ISSUE1, ST_WAIT1, ST_ISSUE2, ST_WAIT2, ST_RESP
  } walkState_e;

  typedef struct packed {
    logic        ldReq;
    logic        ldDir;
    logic        ldPhys;
    logic        ldFault;
    logic        selLeaf;
    faultCause_e cause;
  } walkStrobe_t;

endpackage

// File: rtl/pt_walk_dp.sv
module pt_walk_dp
  import pt_walk_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 13,
  parameter int LEAF_W = 9,
  parameter int ENT_SH = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  walkStrobe_t       strobe,
  input  logic              sysMode,
  input  logic              cfgWrEn,
  input  logic              cfgSel,
  input  logic [ADDR_W-1:0] cfgData,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic              reqUser,
  input  logic [ADDR_W-1:0] memRspData,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic              lenBad,
  output logic              entPresent,
  output logic              permFail,
  output logic [ADDR_W-1:0] rspPhysAddr,
  output logic [1:0]        rspCause,
  output logic [ADDR_W-1:0] curBase,
  output logic [ADDR_W-OFF_W-LEAF_W-1:0] curLen
);
  localparam int DIR_W   = ADDR_W - OFF_W - LEAF_W;
  localparam int FRAME_W = ADDR_W - OFF_W;

  logic [ADDR_W-1:0]  tblBase;
  logic [DIR_W-1:0]   tblLen;
  logic [ADDR_W-1:0]  vaReg;
  logic               wrReg;
  logic               usrReg;
  logic [FRAME_W-1:0] leafTbl;
  logic [ADDR_W-1:0]  physReg;
  logic [1:0]         causeReg;

  logic [DIR_W-1:0]   dirIdx;
  logic [LEAF_W-1:0]  leafIdx;
  logic               unusedBits;

  assign dirIdx  = vaReg[ADDR_W-1 -: DIR_W];
  assign leafIdx = vaReg[OFF_W +: LEAF_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tblBase <= '0;
      tblLen  <= '0;
    end else if (cfgWrEn && sysMode) begin
      if (cfgSel) tblLen  <= cfgData[DIR_W-1:0];
      else        tblBase <= cfgData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaReg    <= '0;
      wrReg    <= 1'b0;
      usrReg   <= 1'b0;
      leafTbl  <= '0;
      physReg  <= '0;
      causeReg <= '0;
    end else begin
      if (strobe.ldReq) begin
        vaReg  <= reqAddr;
        wrReg  <= reqWrite;
        usrReg <= reqUser;
      end
      if (strobe.ldDir) leafTbl <= memRspData[ADDR_W-1:OFF_W];
      if (strobe.ldPhys) begin
        physReg  <= {memRspData[ADDR_W-1:OFF_W], vaReg[OFF_W-1:0]};
        causeReg <= '0;
      end else if (strobe.ldFault) begin
        physReg  <= '0;
        causeReg <= strobe.cause;
      end
    end
  end

  always_comb begin
    if (strobe.selLeaf)
      memReqAddr = {leafTbl, {OFF_W{1'b0}}} + (ADDR_W'(leafIdx) << ENT_SH);
    else
      memReqAddr = tblBase + (ADDR_W'(dirIdx) << ENT_SH);
  end

  assign lenBad     = reqAddr[ADDR_W-1 -: DIR_W] > tblLen;
  assign entPresent = memRspData[PRESENT_BIT];
  assign permFail   = (wrReg && !memRspData[WRITE_BIT]) ||
                      (usrReg && !memRspData[USER_BIT]);

  assign rspPhysAddr = physReg;
  assign rspCause    = causeReg;
  assign curBase     = tblBase;
  assign curLen      = tblLen;
  assign unusedBits  = ^{memRspData[OFF_W-1:USER_BIT+1], memRspData[MOD_BIT:REFD_BIT],
                         cfgData[ADDR_W-1:DIR_W]};
endmodule

// File: rtl/pt_walk_ctl.sv
module pt_walk_ctl
  import pt_walk_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        lenBad,
  input  logic        entPresent,
  input  logic        permFail,
  input  logic        memReqReady,
  input  logic        memRspValid,
  output walkStrobe_t strobe,
  output logic        reqReady,
  output logic        memReqValid,
  output logic        rspValid,
  output logic        rspFault
);
  walkState_e state, nextState;
  logic       faultReg;

  always_comb begin
    strobe      = '0;
    nextState   = state;
    reqReady    = 1'b0;
    memReqValid = 1'b0;
    rspValid    = 1'b0;
    unique case (state)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          strobe.ldReq = 1'b1;
          if (lenBad) begin
            strobe.ldFault = 1'b1;
            strobe.cause   = CAUSE_LEN;
            nextState      = ST_RESP;
          end else begin
            nextState = ST_ISSUE1;
          end
        end
      end
      ST_ISSUE1: begin
        memReqValid = 1'b1;
        if (memReqReady) nextState = ST_WAIT1;
      end
      ST_WAIT1: begin
        if (memRspValid) begin
          if (!entPresent) begin
            strobe.ldFault = 1'b1;
            strobe.cause   = CAUSE_DIR;
            nextState      = ST_RESP;
          end else begin
            strobe.ldDir = 1'b1;
            nextState    = ST_ISSUE2;
          end
        end
      end
      ST_ISSUE2: begin
        memReqValid    = 1'b1;
        strobe.selLeaf = 1'b1;
        if (memReqReady) nextState = ST_WAIT2;
      end
      ST_WAIT2: begin
        if (memRspValid) begin
          nextState = ST_RESP;
          if (!entPresent) begin
            strobe.ldFault = 1'b1;
            strobe.cause   = CAUSE_LEAF;
          end else if (permFail) begin
            strobe.ldFault = 1'b1;
            strobe.cause   = CAUSE_PERM;
          end else begin
            strobe.ldPhys = 1'b1;
          end
        end
      end
      ST_RESP: begin
        rspValid  = 1'b1;
        nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      faultReg <= 1'b0;
    end else begin
      state <= nextState;
      if (strobe.ldPhys)       faultReg <= 1'b0;
      else if (strobe.ldFault) faultReg <= 1'b1;
    end
  end

  assign rspFault = faultReg;
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walk_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 13,
  parameter int LEAF_W = 9,
  parameter int ENT_SH = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sysMode,
  input  logic              cfgWrEn,
  input  logic              cfgSel,
  input  logic [ADDR_W-1:0] cfgData,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic              reqUser,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic [ADDR_W-1:0] memReqAddr,
  input  logic              memRspValid,
  input  logic [ADDR_W-1:0] memRspData,
  output logic              rspValid,
  output logic              rspFault,
  output logic [1:0]        rspCause,
  output logic [ADDR_W-1:0] rspPhysAddr
);
  localparam int DIR_W = ADDR_W - OFF_W - LEAF_W;

  walkStrobe_t       strobe;
  logic              lenBad, entPresent, permFail;
  logic [ADDR_W-1:0] curBase;
  logic [DIR_W-1:0]  curLen;

  pt_walk_ctl u_ctl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .lenBad(lenBad),
    .entPresent(entPresent), .permFail(permFail), .memReqReady(memReqReady),
    .memRspValid(memRspValid), .strobe(strobe), .reqReady(reqReady),
    .memReqValid(memReqValid), .rspValid(rspValid), .rspFault(rspFault)
  );

  pt_walk_dp #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .LEAF_W(LEAF_W), .ENT_SH(ENT_SH)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .sysMode(sysMode), .cfgWrEn(cfgWrEn),
    .cfgSel(cfgSel), .cfgData(cfgData), .reqAddr(reqAddr), .reqWrite(reqWrite),
    .reqUser(reqUser), .memRspData(memRspData), .memReqAddr(memReqAddr),
    .lenBad(lenBad), .entPresent(entPresent), .permFail(permFail),
    .rspPhysAddr(rspPhysAddr), .rspCause(rspCause), .curBase(curBase), .curLen(curLen)
  );
endmodule

// File: rtl/pt_walk_chk.sv
module pt_walk_chk #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 13,
  parameter int DIR_W  = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic              sysMode,
  input logic              cfgWrEn,
  input logic              reqValid,
  input logic              reqReady,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              memReqValid,
  input logic              memReqReady,
  input logic [ADDR_W-1:0] memReqAddr,
  input logic              rspValid,
  input logic              rspFault,
  input logic [1:0]        rspCause,
  input logic [ADDR_W-1:0] rspPhysAddr,
  input logic [ADDR_W-1:0] curBase,
  input logic [DIR_W-1:0]  curLen
);
  logic [OFF_W-1:0] offCap;

  always_ff @(posedge clk) begin
    if (!rstN) offCap <= '0;
    else if (reqValid && reqReady) offCap <= reqAddr[OFF_W-1:0];
  end

  p_hold_req_r9: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid && $stable(memReqAddr));

  p_busy_r9: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> !reqReady);

  p_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid && reqReady);

  p_len_fault_r4: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady && (reqAddr[ADDR_W-1 -: DIR_W] > curLen)
    |=> rspValid && rspFault && rspCause == 2'd0 && !memReqValid);

  p_offset_r1: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && !rspFault |-> rspPhysAddr[OFF_W-1:0] == offCap);

  p_cfg_guard_r8: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrEn && !sysMode |=> $stable(curBase) && $stable(curLen));
endmodule

bind pt_walker pt_walk_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .DIR_W(DIR_W)) u_chk (
  .clk(clk), .rstN(rstN), .sysMode(sysMode), .cfgWrEn(cfgWrEn),
  .reqValid(reqValid), .reqReady(reqReady), .reqAddr(reqAddr),
  .memReqValid(memReqValid), .memReqReady(memReqReady), .memReqAddr(memReqAddr),
  .rspValid(rspValid), .rspFault(rspFault), .rspCause(rspCause),
  .rspPhysAddr(rspPhysAddr), .curBase(curBase), .curLen(curLen)
);

// File: tb/pt_walker_tb.sv
`timescale 1ns/1ps
module pt_walker_tb;
  logic        clk = 0;
  logic        rstN = 0;
  logic        sysMode = 0, cfgWrEn = 0, cfgSel = 0;
  logic [31:0] cfgData = 0;
  logic        reqValid = 0, reqWrite = 0, reqUser = 0;
  logic [31:0] reqAddr = 0;
  logic        reqReady, memReqValid, rspValid, rspFault;
  logic        memReqReady = 0, memRspValid = 0;
  logic [31:0] memReqAddr, rspPhysAddr;
  logic [31:0] memRspData = 0;
  logic [1:0]  rspCause;

  int total = 0, bad = 0;
  logic [31:0] mWords [2];
  logic [31:0] seenAddr [2];
  int readIdx = 0, latCnt = 0, pendIdx = 0;
  logic [31:0] mBase = 0;
  logic [9:0]  mLen = 0;

  always #2.5 clk = ~clk;

  pt_walker u_dut (
    .clk(clk), .rstN(rstN), .sysMode(sysMode), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel),
    .cfgData(cfgData), .reqValid(reqValid), .reqReady(reqReady), .reqAddr(reqAddr),
    .reqWrite(reqWrite), .reqUser(reqUser), .memReqValid(memReqValid),
    .memReqReady(memReqReady), .memReqAddr(memReqAddr), .memRspValid(memRspValid),
    .memRspData(memRspData), .rspValid(rspValid), .rspFault(rspFault),
    .rspCause(rspCause), .rspPhysAddr(rspPhysAddr)
  );

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // memory responder: random accept, 1..3 cycle latency, one-cycle data strobe
  initial begin
    forever begin
      @(negedge clk);
      memRspValid = 0;
      if (latCnt > 0) begin
        latCnt--;
        if (latCnt == 0) begin
          memRspData  = mWords[pendIdx];
          memRspValid = 1;
        end
      end
      memReqReady = ($urandom % 2) == 1;
      if (memReqValid && memReqReady) begin
        if (readIdx < 2) seenAddr[readIdx] = memReqAddr;
        pendIdx = (readIdx < 2) ? readIdx : 1;
        readIdx++;
        latCnt = 1 + ($urandom % 3);
      end
    end
  end

  task automatic cfgWrite(input logic priv, input logic sel, input logic [31:0] d);
    @(negedge clk);
    sysMode = priv; cfgSel = sel; cfgData = d; cfgWrEn = 1;
    @(negedge clk);
    cfgWrEn = 0; sysMode = 0;
    if (priv) begin
      if (sel) mLen = d[9:0];
      else     mBase = d;
    end
  endtask

  // reference model built from R1..R7
  task automatic refWalk(input logic [31:0] va, input logic wr, input logic us,
                         input logic [31:0] dirE, input logic [31:0] leafE,
                         output logic flt, output logic [1:0] cause, output logic [31:0] pa,
                         output int reads, output logic [31:0] a1, output logic [31:0] a2);
    logic [9:0] p1 = va[31:22];
    logic [8:0] p2 = va[21:13];
    a1 = mBase + {20'd0, p1, 2'b00};
    a2 = {dirE[31:13], 13'd0} + {21'd0, p2, 2'b00};
    pa = 0; flt = 1; cause = 0; reads = 0;
    if (p1 > mLen) begin cause = 0; reads = 0; end
    else if (!dirE[0]) begin cause = 1; reads = 1; end
    else begin
      reads = 2;
      if (!leafE[0]) cause = 2;
      else if ((wr && !leafE[3]) || (us && !leafE[4])) cause = 3;
      else begin flt = 0; pa = {leafE[31:13], va[12:0]}; end
    end
  endtask

  task automatic walk(input string tag, input logic [31:0] va, input logic wr, input logic us,
                      input logic [31:0] dirE, input logic [31:0] leafE);
    logic eFlt; logic [1:0] eCause; logic [31:0] ePa, eA1, eA2; int eReads; int n;
    refWalk(va, wr, us, dirE, leafE, eFlt, eCause, ePa, eReads, eA1, eA2);
    mWords[0] = dirE; mWords[1] = leafE;
    @(negedge clk);
    readIdx = 0;
    reqAddr = va; reqWrite = wr; reqUser = us; reqValid = 1;
    check("R9", "ready when idle", {31'd0, reqReady}, 32'd1);
    @(negedge clk);
    reqValid = 0;
    n = 0;
    while (!rspValid && n < 60) begin @(negedge clk); n++; end
    check(tag, "rspValid", {31'd0, rspValid}, 32'd1);
    check(tag, "fault", {31'd0, rspFault}, {31'd0, eFlt});
    check(tag, "cause", {30'd0, rspCause}, {30'd0, eCause});
    check(tag, "phys", rspPhysAddr, ePa);
    check(tag, "read count", readIdx, eReads);
    if (eReads >= 1) check("R2", "dir addr", seenAddr[0], eA1);
    if (eReads == 2) check("R3", "leaf addr", seenAddr[1], eA2);
    @(negedge clk);
    check("R9", "pulse ends", {31'd0, rspValid}, 32'd0);
  endtask

  initial begin
    #(5.0 * 150000);
    bad++; total++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R10", "reqReady in reset", {31'd0, reqReady}, 32'd1);
    check("R10", "memReqValid in reset", {31'd0, memReqValid}, 32'd0);
    check("R10", "rspValid in reset", {31'd0, rspValid}, 32'd0);
    rstN = 1;
    @(negedge clk);
    check("R10", "reqReady after reset", {31'd0, reqReady}, 32'd1);
    // R10: length 0 after reset -> index 1 faults, base 0 -> index 0 read at 0
    walk("R10", 32'h0040_0000, 0, 0, 32'h1, 32'h1);
    walk("R10", 32'h0000_1234, 0, 0, 32'h0000_2019, 32'h0001_4019);

    cfgWrite(1, 0, 32'h0010_0000);
    cfgWrite(1, 1, 32'h0000_03FF);
    // R1 success, R2/R3 addresses
    walk("R1", 32'h1234_5678, 0, 0, 32'hABCD_E001, 32'h7654_2019);
    walk("R1", 32'hFFFF_FFFF, 1, 1, 32'h0000_2001, 32'hFFFF_E019);
    // R5 directory absent
    walk("R5", 32'h0080_0000, 0, 0, 32'hABCD_E01E, 32'h1);
    // R6 leaf absent
    walk("R6", 32'h0080_2000, 0, 0, 32'h0004_0001, 32'h1234_E01E);
    // R7 permission: write denied, user denied, absence beats permission
    walk("R7", 32'h0080_2FFF, 1, 0, 32'h0004_0001, 32'h1234_E011);
    walk("R7", 32'h0080_2FFF, 0, 1, 32'h0004_0001, 32'h1234_E009);
    walk("R7", 32'h0080_2FFF, 1, 1, 32'h0004_0001, 32'h1234_E000);
    walk("R7", 32'h0080_2FFF, 1, 1, 32'h0004_0001, 32'h1234_E019);
    // R4 length bound, boundary
    cfgWrite(1, 1, 32'h0000_0005);
    walk("R4", 32'h0180_0000, 0, 0, 32'h0004_0001, 32'h0000_2019);
    walk("R4", 32'h0140_0000, 0, 0, 32'h0004_0001, 32'h0000_2019);
    // R8 user-mode write ignored: base and length unchanged
    @(negedge clk);
    sysMode = 0; cfgSel = 0; cfgData = 32'h0F00_0000; cfgWrEn = 1;
    @(negedge clk);
    cfgSel = 1; cfgData = 32'h3FF;
    @(negedge clk);
    cfgWrEn = 0;
    walk("R8", 32'h0140_0000, 0, 0, 32'h0004_0001, 32'h0000_2019);
    walk("R8", 32'h0180_0000, 0, 0, 32'h0004_0001, 32'h0000_2019);

    for (int i = 0; i < 300; i++) begin
      logic [31:0] va, d1, d2;
      if (i % 50 == 0) begin
        cfgWrite(1, 0, $urandom & 32'hFFFF_FFFC);
        cfgWrite(1, 1, ($urandom % 2) ? 32'h3FF : ($urandom % 1024));
      end
      va = $urandom;
      d1 = {$urandom} & 32'hFFFF_FFFE | (($urandom % 8) != 0 ? 32'h1 : 32'h0);
      d2 = {$urandom} & 32'hFFFF_FFFE | (($urandom % 8) != 0 ? 32'h1 : 32'h0);
      walk("R1", va, $urandom % 2, $urandom % 2, d1, d2);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule